// File: doc/BRIEF.md
# Four-Cache Snooping Coherence Controller

This block keeps one shared memory word coherent across four private processor caches that sit on a common snooping bus. Each cache holds a single line made of a MESI state (Invalid, Shared, Exclusive, Modified) and a data word. The block also keeps the memory copy of that word.

Each clock edge it accepts at most one access: a load, or a store with write data, from one processor. At that edge it moves every cache's state and data to the next value and updates memory. One cycle later it reports three things: the bus operation the access needed, which agent supplied the line, and the value a load returned.

A dirty owner that serves a reader also writes the line back to memory. The states and memory are visible at the ports, so the effect of each access can be observed.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every cache field of `cache_state_o` reads Invalid (code 0), `mem_data_o` is 0 and `rsp_valid` is 0. The field of cache i is `cache_state_o[2i+1:2i]`, with codes I=0, S=1, E=2, M=3.
- R2: A load from an Invalid cache while no other cache holds a valid copy reports bus Read (`rsp_busop` 1) and supplier memory (`rsp_supplier` 1). It returns the memory value, and the requester goes to Exclusive.
- R3: A load from an Invalid cache while other caches hold only Exclusive or Shared copies reports bus Read with supplier memory. The requester goes to Shared, a former Exclusive holder goes to Shared, and Shared holders stay Shared.
- R4: A load from an Invalid cache while another cache is Modified reports bus Read with that owner as supplier. The supplier code for cache i is 4+i. The load returns the owner's data, memory is written with that data, and both caches end in Shared.
- R5: A store from a Shared cache reports Read-Exclusive (`rsp_busop` 2) with the requester's own cache as supplier. The requester goes to Modified holding the write data, and every other cache goes to Invalid.
- R6: A store from an Invalid cache while another cache is Modified reports Read-Exclusive-Invalidate (`rsp_busop` 3) with the old owner as supplier. The old owner goes to Invalid, the requester goes to Modified with the write data, and memory is unchanged.
- R7: A store from an Invalid cache while no other cache is Modified reports Read-Exclusive with supplier memory. All other copies go to Invalid, and the requester goes to Modified.
- R8: A load hit in M, E or S, a store hit in M, and a store hit in E report bus None (0) and supplier none (0). A load hit returns the cache's own data and changes nothing. A store hit writes the data locally: a store hit in E moves that cache to Modified, and memory is not touched.
- R9: At any time at most one cache is in Modified or Exclusive, and while one is, every other cache is Invalid.
- R10: A cycle without `req_valid` changes no cache state and no memory value, and gives `rsp_valid` 0 on the next cycle.
- R11: State and memory updates take effect at the edge that samples `req_valid`. The response shows up, registered, with `rsp_valid` 1 in the following cycle. Stores report `rsp_rdata` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe |
| req_id | input | 2 | Requesting cache index |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_busop | output | 2 | Bus operation: 0 None, 1 Read, 2 Read-Exclusive, 3 Read-Exclusive-Invalidate |
| rsp_supplier | output | 3 | 0 none, 1 memory, 4+i cache i |
| rsp_rdata | output | 8 | Load result; 0 for stores |
| cache_state_o | output | 8 | Packed per-cache MESI state, 2 bits each |
| mem_data_o | output | 8 | Memory copy of the word |

## Verification
The assertions assume three things about the inputs: at most one access arrives per cycle, `req_id` always names one of the four caches, and the request fields are only meaningful in a cycle where `req_valid` is high. The directed stimulus drives a single request per strobe, always with an index from 0 to 3, and drops the strobe between accesses. During idle cycles it deliberately puts junk store data and a store flag on the request lines, which shows that nothing outside a strobe is taken into account. The checker relies on the supplier and state fields obeying the encodings above; it reads the owner's state field using the supplier's low bits.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RDX  = 2'd2,
        BUS_RDXI = 2'd3
    } bus_op_e;
endpackage

// File: rtl/mesi_peer_scan.sv
`timescale 1ns/1ps
module mesi_peer_scan
    import mesi_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int ID_W       = 2
) (
    input  line_st_e          st_i [NUM_CACHES],
    input  logic [ID_W-1:0]   req_id_i,
    output logic              peer_m_o,
    output logic [ID_W-1:0]   peer_m_idx_o,
    output logic              peer_clean_o
);
    // Summarise the other caches' states as seen from the requester.
    always_comb begin
        peer_m_o     = 1'b0;
        peer_m_idx_o = '0;
        peer_clean_o = 1'b0;
        for (int i = 0; i < NUM_CACHES; i++) begin
            if (ID_W'(i) != req_id_i) begin
                unique case (st_i[i])
                    ST_M: begin
                        peer_m_o     = 1'b1;
                        peer_m_idx_o = ID_W'(i);
                    end
                    ST_E, ST_S: peer_clean_o = 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mesi_txn_ctrl.sv
`timescale 1ns/1ps
module mesi_txn_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int ID_W       = 2,
    parameter int DATA_W     = 8,
    parameter int SUP_W      = ID_W + 1
) (
    input  line_st_e           st_i      [NUM_CACHES],
    input  logic [DATA_W-1:0]  data_i    [NUM_CACHES],
    input  logic [DATA_W-1:0]  mem_i,
    input  logic [ID_W-1:0]    req_id_i,
    input  logic               req_store_i,
    input  logic [DATA_W-1:0]  req_wdata_i,
    input  logic               peer_m_i,
    input  logic [ID_W-1:0]    peer_m_idx_i,
    input  logic               peer_clean_i,
    output line_st_e           nxt_st_o  [NUM_CACHES],
    output logic [DATA_W-1:0]  nxt_data_o[NUM_CACHES],
    output logic               mem_we_o,
    output logic [DATA_W-1:0]  mem_wd_o,
    output bus_op_e            busop_o,
    output logic [SUP_W-1:0]   sup_o,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam logic [SUP_W-1:0] SUP_NONE = SUP_W'(0);
    localparam logic [SUP_W-1:0] SUP_MEM  = SUP_W'(1);

    line_st_e own_st;
    assign own_st = st_i[req_id_i];

    always_comb begin
        for (int i = 0; i < NUM_CACHES; i++) begin
            nxt_st_o[i]   = st_i[i];
            nxt_data_o[i] = data_i[i];
        end
        mem_we_o = 1'b0;
        mem_wd_o = mem_i;
        busop_o  = BUS_NONE;
        sup_o    = SUP_NONE;
        rdata_o  = '0;

        if (!req_store_i) begin
            unique case (own_st)
                ST_M, ST_E, ST_S: rdata_o = data_i[req_id_i];   // load hit
                ST_I: begin
                    busop_o = BUS_RD;
                    if (peer_m_i) begin                          // dirty owner serves and writes back
                        sup_o                    = {1'b1, peer_m_idx_i};
                        rdata_o                  = data_i[peer_m_idx_i];
                        mem_we_o                 = 1'b1;
                        mem_wd_o                 = data_i[peer_m_idx_i];
                        nxt_st_o[peer_m_idx_i]   = ST_S;
                        nxt_st_o[req_id_i]       = ST_S;
                        nxt_data_o[req_id_i]     = data_i[peer_m_idx_i];
                    end else begin
                        sup_o   = SUP_MEM;
                        rdata_o = mem_i;
                        for (int i = 0; i < NUM_CACHES; i++)
                            if (st_i[i] == ST_E) nxt_st_o[i] = ST_S;
                        nxt_st_o[req_id_i]   = peer_clean_i ? ST_S : ST_E;
                        nxt_data_o[req_id_i] = mem_i;
                    end
                end
            endcase
        end else begin
            nxt_st_o[req_id_i]   = ST_M;
            nxt_data_o[req_id_i] = req_wdata_i;
            unique case (own_st)
                ST_M, ST_E: ;                                    // silent store hit
                ST_S: begin
                    busop_o = BUS_RDX;
                    sup_o   = {1'b1, req_id_i};
                end
                ST_I: begin
                    if (peer_m_i) begin
                        busop_o = BUS_RDXI;
                        sup_o   = {1'b1, peer_m_idx_i};
                    end else begin
                        busop_o = BUS_RDX;
                        sup_o   = SUP_MEM;
                    end
                end
            endcase
            if (own_st == ST_S || own_st == ST_I) begin
                for (int i = 0; i < NUM_CACHES; i++)
                    if (ID_W'(i) != req_id_i) nxt_st_o[i] = ST_I;
            end
        end
    end
endmodule

// File: rtl/mesi_line.sv
`timescale 1ns/1ps
module mesi_line
    import mesi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  line_st_e          nxt_st_i,
    input  logic [DATA_W-1:0] nxt_data_i,
    output line_st_e          st_o,
    output logic [DATA_W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_o   <= ST_I;
            data_o <= '0;
        end else if (upd_i) begin
            st_o   <= nxt_st_i;
            data_o <= nxt_data_i;
        end
    end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter  int NUM_CACHES = 4,
    parameter  int DATA_W     = 8,
    localparam int ID_W       = $clog2(NUM_CACHES),
    localparam int SUP_W      = ID_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ID_W-1:0]         req_id,
    input  logic                    req_store,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic [1:0]              rsp_busop,
    output logic [SUP_W-1:0]        rsp_supplier,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic [2*NUM_CACHES-1:0] cache_state_o,
    output logic [DATA_W-1:0]       mem_data_o
);
    line_st_e          st       [NUM_CACHES];
    logic [DATA_W-1:0] data     [NUM_CACHES];
    line_st_e          nxt_st   [NUM_CACHES];
    logic [DATA_W-1:0] nxt_data [NUM_CACHES];

    logic              peer_m, peer_clean;
    logic [ID_W-1:0]   peer_m_idx;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wd, mem_q;
    bus_op_e           busop;
    logic [SUP_W-1:0]  sup;
    logic [DATA_W-1:0] rdata;

    mesi_peer_scan #(.NUM_CACHES(NUM_CACHES), .ID_W(ID_W)) u_scan (
        .st_i         (st),
        .req_id_i     (req_id),
        .peer_m_o     (peer_m),
        .peer_m_idx_o (peer_m_idx),
        .peer_clean_o (peer_clean)
    );

    mesi_txn_ctrl #(.NUM_CACHES(NUM_CACHES), .ID_W(ID_W), .DATA_W(DATA_W), .SUP_W(SUP_W)) u_txn (
        .st_i         (st),
        .data_i       (data),
        .mem_i        (mem_q),
        .req_id_i     (req_id),
        .req_store_i  (req_store),
        .req_wdata_i  (req_wdata),
        .peer_m_i     (peer_m),
        .peer_m_idx_i (peer_m_idx),
        .peer_clean_i (peer_clean),
        .nxt_st_o     (nxt_st),
        .nxt_data_o   (nxt_data),
        .mem_we_o     (mem_we),
        .mem_wd_o     (mem_wd),
        .busop_o      (busop),
        .sup_o        (sup),
        .rdata_o      (rdata)
    );

    for (genvar g = 0; g < NUM_CACHES; g++) begin : g_line
        mesi_line #(.DATA_W(DATA_W)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .upd_i      (req_valid),
            .nxt_st_i   (nxt_st[g]),
            .nxt_data_i (nxt_data[g]),
            .st_o       (st[g]),
            .data_o     (data[g])
        );
        assign cache_state_o[2*g +: 2] = st[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  mem_q <= '0;
        else if (req_valid && mem_we) mem_q <= mem_wd;
    end
    assign mem_data_o = mem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_busop    <= BUS_NONE;
            rsp_supplier <= '0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_busop    <= req_valid ? busop : BUS_NONE;
            rsp_supplier <= req_valid ? sup   : '0;
            rsp_rdata    <= req_valid ? rdata : '0;
        end
    end
endmodule

// File: rtl/mesi_snoop_checker.sv
`timescale 1ns/1ps
module mesi_snoop_checker #(
    parameter  int NUM_CACHES = 4,
    parameter  int DATA_W     = 8,
    localparam int ID_W       = $clog2(NUM_CACHES),
    localparam int SUP_W      = ID_W + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    rsp_valid,
    input logic [1:0]              rsp_busop,
    input logic [SUP_W-1:0]        rsp_supplier,
    input logic [DATA_W-1:0]       rsp_rdata,
    input logic [2*NUM_CACHES-1:0] cache_state_o,
    input logic [DATA_W-1:0]       mem_data_o
);
    logic [NUM_CACHES-1:0] owner_v, valid_v;
    logic [1:0]            sup_field;
    logic                  sup_is_cache;

    always_comb begin
        for (int i = 0; i < NUM_CACHES; i++) begin
            owner_v[i] = cache_state_o[2*i+1];
            valid_v[i] = cache_state_o[2*i +: 2] != 2'd0;
        end
        sup_field    = cache_state_o[2*int'(rsp_supplier[ID_W-1:0]) +: 2];
        sup_is_cache = rsp_supplier[SUP_W-1];
    end

    a_r9_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(owner_v) <= 1);
    a_r9_owner_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_v != '0) |-> ($countones(valid_v) == 1));
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(cache_state_o) && $stable(mem_data_o) && !rsp_valid));
    a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r4_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_busop == 2'd1 && sup_is_cache) |-> (mem_data_o == rsp_rdata && sup_field == 2'd1));
    a_r6_owner_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_busop == 2'd3) |-> (sup_is_cache && sup_field == 2'd0));
    a_r5_upgrade_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_busop == 2'd2 && sup_is_cache) |-> (sup_field == 2'd3));
    a_r8_no_bus_no_supplier: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_busop == 2'd0) |-> (rsp_supplier == '0));
endmodule

bind mesi_snoop_ctrl mesi_snoop_checker #(.NUM_CACHES(NUM_CACHES), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rsp_valid     (rsp_valid),
    .rsp_busop     (rsp_busop),
    .rsp_supplier  (rsp_supplier),
    .rsp_rdata     (rsp_rdata),
    .cache_state_o (cache_state_o),
    .mem_data_o    (mem_data_o)
);

// File: tb/mesi_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_id = '0;
    logic       req_store = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [1:0] rsp_busop;
    logic [2:0] rsp_supplier;
    logic [7:0] rsp_rdata;
    logic [7:0] cache_state_o;
    logic [7:0] mem_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mesi_snoop_ctrl u_mesi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_store(req_store), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_busop(rsp_busop), .rsp_supplier(rsp_supplier), .rsp_rdata(rsp_rdata),
        .cache_state_o(cache_state_o), .mem_data_o(mem_data_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit owner_rule_ok(input logic [7:0] s);
        int own = 0, vld = 0;
        for (int i = 0; i < 4; i++) begin
            if (s[2*i+1]) own++;
            if (s[2*i +: 2] != 2'd0) vld++;
        end
        return (own == 0) || (own == 1 && vld == 1);
    endfunction

    task automatic apply_reset();
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 states", cache_state_o, 8'h00);
        check("R1 memory", mem_data_o, 8'h00);
        check("R1 rsp_valid", rsp_valid, 0);
    endtask

    // One strobe, then compare every output one edge later.
    task automatic access(input string tag, input int id, input bit st, input int wd,
                          input int e_op, input int e_sup, input int e_rd,
                          input int e_states, input int e_mem);
        req_id = 2'(id); req_store = st; req_wdata = 8'(wd); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R11 rsp_valid"}, rsp_valid, 1);
        check({tag, " busop"}, rsp_busop, e_op);
        check({tag, " supplier"}, rsp_supplier, e_sup);
        check({tag, " rdata"}, rsp_rdata, e_rd);
        check({tag, " states"}, cache_state_o, e_states);
        check({tag, " memory"}, mem_data_o, e_mem);
        check({tag, " R9 owner rule"}, owner_rule_ok(cache_state_o), 1);
    endtask

    task automatic t_sharing_sequence();
        access("R2 c0 load empty",      0, 0, 0, 1, 1, 0, 8'h02, 0);
        access("R3 c1 load vs E",       1, 0, 0, 1, 1, 0, 8'h05, 0);
        access("R5 c0 store from S",    0, 1, 1, 2, 4, 0, 8'h03, 0);
        access("R4 c2 load vs M",       2, 0, 0, 1, 4, 1, 8'h11, 1);
        access("R5 c2 store from S",    2, 1, 2, 2, 6, 0, 8'h30, 1);
        access("R4 c1 load vs M",       1, 0, 0, 1, 6, 2, 8'h14, 2);
        access("R3 c0 load vs S only",  0, 0, 0, 1, 1, 2, 8'h15, 2);
    endtask

    task automatic t_hits_and_misses();
        access("R8 c1 load hit S",        1, 0, 0, 0, 0, 2, 8'h15, 2);
        access("R7 c3 store miss clean",  3, 1, 9, 2, 1, 0, 8'hC0, 2);
        access("R8 c3 store hit M",       3, 1, 10, 0, 0, 0, 8'hC0, 2);
        access("R6 c0 store vs M",        0, 1, 7, 3, 7, 0, 8'h03, 2);
        access("R8 c0 load hit M",        0, 0, 0, 0, 0, 7, 8'h03, 2);
    endtask

    task automatic t_idle_ignored();
        req_id = 2'd2; req_store = 1'b1; req_wdata = 8'hA5;   // junk without strobe
        repeat (3) @(negedge clk);
        check("R10 rsp_valid idle", rsp_valid, 0);
        check("R10 states idle", cache_state_o, 8'h03);
        check("R10 memory idle", mem_data_o, 2);
    endtask

    task automatic t_exclusive_paths();
        apply_reset();
        access("R2 c2 load empty",     2, 0, 0, 1, 1, 0, 8'h20, 0);
        access("R8 c2 store hit E",    2, 1, 5, 0, 0, 0, 8'h30, 0);
        access("R8 c2 load hit M",     2, 0, 0, 0, 0, 5, 8'h30, 0);
        access("R6 c1 store vs M",     1, 1, 6, 3, 6, 0, 8'h0C, 0);
        access("R4 c3 load vs M",      3, 0, 0, 1, 5, 6, 8'h44, 6);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        apply_reset();
        t_sharing_sequence();
        t_hits_and_misses();
        t_idle_ignored();
        t_exclusive_paths();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule